// File: doc/BRIEF.md
# Memory Access Privilege and Capacity Checker

This block sits beside the memory targets of a bus fabric and judges each transfer before it reaches a memory. For every access it receives the byte offset inside the addressed memory, a code naming that memory (boot ROM partition, system ROM partition, first SRAM, second SRAM or flash) and a privilege bit. It answers at once, in the same cycle, with either a grant or a bus-error indication. A second error flag tells the fabric when the error comes from the capacity check rather than from the privilege check.

Two kinds of setting drive the verdict, and both are held in registers written through a narrow field-write port. The first kind is a user limit per memory. It is counted in 256-byte units and marks where the privileged area begins. The system ROM limit is counted from the first byte of the boot ROM partition, so the two ROM partitions share one scale. The second kind is a capacity reduction code for each SRAM and for flash. It shrinks the usable part of that memory to a power-of-two fraction. Its bits can be set by writes but never cleared, except by reset.

Top module: `memprot_top`

## Requirements
- R1: With `acc_valid` low, `acc_ok`, `acc_err` and `acc_cap_err` are all 0. With `acc_valid` high, exactly one of `acc_ok` and `acc_err` is 1.
- R2: Memory codes are 0 boot ROM, 1 system ROM, 2 first SRAM, 3 second SRAM, 4 flash. For codes 0, 2, 3 and 4, a user access (`acc_priv`=0) at offset A is granted only when A/256 (rounded down) is less than that memory's limit. A limit of 0 therefore blocks all user accesses, and a limit at or above the memory size in 256-byte units opens the whole memory.
- R3: For system ROM, a user access at offset A is granted only when (boot partition bytes + A)/256 is less than the system ROM limit. A limit times 256 that does not exceed the boot partition size blocks all of system ROM to users.
- R4: A privileged access (`acc_priv`=1) is never refused by a limit.
- R5: Limit writes keep only the low 8 bits for both ROM limits, the low 9 bits for each SRAM limit and all 12 bits for flash.
- R6: After reset, every limit is 0 except the second SRAM limit, which is 0x1FF. Every capacity code is 0.
- R7: A capacity code k on an SRAM or on flash leaves only offsets below size/2^k usable. An access at or above that bound gets `acc_err`=1 and `acc_cap_err`=1, whatever its privilege.
- R8: A capacity-code write stores the OR of the old code and the low 3 bits of the written data, so no bit is ever cleared by a write.
- R9: When the capacity check and the privilege check both fail, the error is reported as a capacity error (`acc_cap_err`=1). An error caused only by privilege has `acc_cap_err`=0.
- R10: An offset at or beyond the addressed memory's size gives `acc_err`=1 with `acc_cap_err`=1. Memory codes 5 to 7 give `acc_err`=1 with `acc_cap_err`=0.
- R11: Field select codes on `cfg_sel` are 0 to 4 for the limits of memory codes 0 to 4, and 5, 6 and 7 for the capacity codes of the first SRAM, the second SRAM and flash. A write applies at the rising clock edge where `cfg_we` is high, and the verdict uses the new value from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Field write strobe |
| cfg_sel | input | 3 | Field select code |
| cfg_wdata | input | 12 | Field write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_mem | input | 3 | Target memory code |
| acc_addr | input | ADDR_W (16) | Byte offset within target memory |
| acc_priv | input | 1 | 1 = privileged, 0 = user |
| acc_ok | output | 1 | Access granted |
| acc_err | output | 1 | Access refused, bus error |
| acc_cap_err | output | 1 | Refusal caused by capacity or range |

## Verification
A corrupted limit or capacity register does not stay hidden. The next access to that memory near the affected boundary flips between grant and error in the same cycle, because the verdict is combinational from the stored fields. A capacity register that lost a set bit shows up as a grant above the reduced bound. A wrong field width or a wrong reset value shows up as a grant or refusal at an offset one 256-byte unit away from the expected edge. The vectors therefore probe both sides of each boundary right after the write that moves it.

// File: rtl/memprot_pkg.sv
`timescale 1ns/1ps
package memprot_pkg;

    localparam int NUM_MEM    = 5;
    localparam int LIM_W      = 12;
    localparam int CAP_W      = 3;
    localparam int UNIT_SHIFT = 8;

    typedef enum logic [2:0] {
        MEM_BOOT  = 3'd0,
        MEM_SYS   = 3'd1,
        MEM_RAM0  = 3'd2,
        MEM_RAM1  = 3'd3,
        MEM_FLASH = 3'd4
    } mem_e;

    typedef struct packed {
        logic [LIM_W-1:0] lim;
        logic [CAP_W-1:0] cap;
    } mem_cfg_t;

    typedef struct packed {
        logic ok;
        logic err;
        logic cap_err;
    } verdict_t;

    function automatic int lim_width(int i);
        case (i)
            0, 1:    return 8;
            2, 3:    return 9;
            default: return 12;
        endcase
    endfunction

    function automatic logic [LIM_W-1:0] lim_mask(int i);
        logic [LIM_W-1:0] m;
        m = '1;
        return m >> (LIM_W - lim_width(i));
    endfunction

    function automatic logic [LIM_W-1:0] lim_reset(int i);
        return (i == int'(MEM_RAM1)) ? 12'h1FF : 12'h000;
    endfunction

    function automatic bit cap_capable(int i);
        return i >= int'(MEM_RAM0);
    endfunction

    function automatic logic [2:0] lim_field(int i);
        return 3'(i);
    endfunction

    function automatic logic [2:0] cap_field(int i);
        return 3'(i + 3);
    endfunction

endpackage

// File: rtl/memprot_cfg_regs.sv
`timescale 1ns/1ps
module memprot_cfg_regs
    import memprot_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [2:0]                sel,
    input  logic [LIM_W-1:0]          wdata,
    output mem_cfg_t [NUM_MEM-1:0]    cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_MEM; i++) begin
                cfg_q[i].lim <= lim_reset(i);
                cfg_q[i].cap <= '0;
            end
        end else if (we) begin
            for (int i = 0; i < NUM_MEM; i++) begin
                if (sel == lim_field(i))
                    cfg_q[i].lim <= wdata & lim_mask(i);
                if (cap_capable(i) && sel == cap_field(i))
                    cfg_q[i].cap <= cfg_q[i].cap | wdata[CAP_W-1:0];
            end
        end
    end

endmodule

// File: rtl/memprot_region.sv
`timescale 1ns/1ps
module memprot_region
    import memprot_pkg::*;
#(
    parameter int unsigned BASE_B  = 0,
    parameter int unsigned SIZE_B  = 4096,
    parameter bit          CAP_EN  = 1'b0,
    parameter int          ADDR_W  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  mem_cfg_t          cfg,
    output logic              in_range,
    output logic              cap_ok,
    output logic              user_ok
);

    logic [31:0] off;
    logic [31:0] pos;

    always_comb begin
        off      = 32'(addr);
        pos      = 32'(BASE_B) + off;
        in_range = off < 32'(SIZE_B);
        user_ok  = (pos >> UNIT_SHIFT) < 32'(cfg.lim);
    end

    generate
        if (CAP_EN) begin : g_cap
            logic [31:0] cap_b;
            always_comb begin
                cap_b  = 32'(SIZE_B) >> cfg.cap;
                cap_ok = off < cap_b;
            end
        end else begin : g_nocap
            assign cap_ok = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/memprot_top.sv
`timescale 1ns/1ps
module memprot_top
    import memprot_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int BOOT_UNITS  = 16,
    parameter int SYS_UNITS   = 32,
    parameter int RAM0_UNITS  = 32,
    parameter int RAM1_UNITS  = 16,
    parameter int FLASH_UNITS = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [LIM_W-1:0]  cfg_wdata,
    input  logic              acc_valid,
    input  logic [2:0]        acc_mem,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_priv,
    output logic              acc_ok,
    output logic              acc_err,
    output logic              acc_cap_err
);

    localparam int unsigned SIZE_U [NUM_MEM] =
        '{BOOT_UNITS, SYS_UNITS, RAM0_UNITS, RAM1_UNITS, FLASH_UNITS};
    localparam int unsigned BASE_U [NUM_MEM] =
        '{0, BOOT_UNITS, 0, 0, 0};
    localparam logic [2:0] MEM_LAST = 3'(NUM_MEM - 1);

    mem_cfg_t [NUM_MEM-1:0] cfg_q;
    logic [NUM_MEM-1:0]     in_rng;
    logic [NUM_MEM-1:0]     cap_ok;
    logic [NUM_MEM-1:0]     usr_ok;

    memprot_cfg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q)
    );

    generate
        for (genvar i = 0; i < NUM_MEM; i++) begin : g_mem
            memprot_region #(
                .BASE_B (BASE_U[i] << UNIT_SHIFT),
                .SIZE_B (SIZE_U[i] << UNIT_SHIFT),
                .CAP_EN (cap_capable(i)),
                .ADDR_W (ADDR_W)
            ) u_region (
                .addr     (acc_addr),
                .cfg      (cfg_q[i]),
                .in_range (in_rng[i]),
                .cap_ok   (cap_ok[i]),
                .user_ok  (usr_ok[i])
            );
        end
    endgenerate

    logic       sel_ok;
    logic [2:0] idx;
    logic       cap_fail;
    logic       priv_fail;
    verdict_t   vd;

    always_comb begin
        sel_ok    = acc_mem <= MEM_LAST;
        idx       = sel_ok ? acc_mem : 3'd0;
        cap_fail  = !(in_rng[idx] && cap_ok[idx]);
        priv_fail = !acc_priv && !usr_ok[idx];
        vd        = '0;
        if (acc_valid) begin
            if (!sel_ok) begin
                vd.err = 1'b1;
            end else if (cap_fail) begin
                vd.err     = 1'b1;
                vd.cap_err = 1'b1;
            end else if (priv_fail) begin
                vd.err = 1'b1;
            end else begin
                vd.ok = 1'b1;
            end
        end
    end

    assign acc_ok      = vd.ok;
    assign acc_err     = vd.err;
    assign acc_cap_err = vd.cap_err;

endmodule

// File: rtl/memprot_chk.sv
`timescale 1ns/1ps
module memprot_chk
    import memprot_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   acc_valid,
    input logic [2:0]             acc_mem,
    input logic                   acc_priv,
    input logic                   acc_ok,
    input logic                   acc_err,
    input logic                   acc_cap_err,
    input mem_cfg_t [NUM_MEM-1:0] cfg_q
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> (!acc_ok && !acc_err && !acc_cap_err));

    assert_one_verdict_R1: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> (acc_ok != acc_err));

    assert_priv_no_limit_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_priv && acc_mem <= 3'd4 && !acc_cap_err) |-> acc_ok);

    assert_cap_means_err_R9: assert property (@(posedge clk) disable iff (rst)
        acc_cap_err |-> acc_err);

    assert_bad_code_R10: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_mem > 3'd4) |-> (acc_err && !acc_cap_err));

    assert_ram1_reset_open_R6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_q[MEM_RAM1].lim == 12'h1FF && cfg_q[MEM_FLASH].cap == 3'd0));

    generate
        for (genvar i = 2; i < NUM_MEM; i++) begin : g_sticky
            assert_cap_sticky_R8: assert property (@(posedge clk) disable iff (rst)
                (cfg_q[i].cap & $past(cfg_q[i].cap)) == $past(cfg_q[i].cap));
        end
    endgenerate

endmodule

bind memprot_top memprot_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .acc_valid   (acc_valid),
    .acc_mem     (acc_mem),
    .acc_priv    (acc_priv),
    .acc_ok      (acc_ok),
    .acc_err     (acc_err),
    .acc_cap_err (acc_cap_err),
    .cfg_q       (cfg_q)
);

// File: tb/memprot_top_test.sv
`timescale 1ns/1ps
module memprot_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [11:0] cfg_wdata = 12'd0;
    logic        acc_valid = 1'b0;
    logic [2:0]  acc_mem = 3'd0;
    logic [15:0] acc_addr = 16'd0;
    logic        acc_priv = 1'b0;
    logic        acc_ok, acc_err, acc_cap_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    memprot_top uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_mem(acc_mem),
        .acc_addr(acc_addr), .acc_priv(acc_priv), .acc_ok(acc_ok),
        .acc_err(acc_err), .acc_cap_err(acc_cap_err)
    );

    typedef struct packed {
        logic        wr;
        logic [2:0]  sel;
        logic [11:0] wd;
        logic        v;
        logic [2:0]  mem;
        logic [15:0] addr;
        logic        pr;
        logic        eo;
        logic        ee;
        logic        ec;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    // wr sel wdata | valid mem addr priv | ok err cap | requirement
    localparam vec_t VECS [NV] = '{
        '{1'b0,3'd0,12'h000, 1'b0,3'd0,16'h0000,1'b0, 1'b0,1'b0,1'b0, 4'd1},  // R1 idle
        '{1'b0,3'd0,12'h000, 1'b1,3'd0,16'h0000,1'b0, 1'b0,1'b1,1'b0, 4'd6},  // R6 boot lim 0
        '{1'b0,3'd0,12'h000, 1'b1,3'd0,16'h0000,1'b1, 1'b1,1'b0,1'b0, 4'd4},  // R4
        '{1'b0,3'd0,12'h000, 1'b1,3'd3,16'h0FFF,1'b0, 1'b1,1'b0,1'b0, 4'd6},  // R6 ram1 open
        '{1'b1,3'd0,12'h105, 1'b1,3'd0,16'h04FF,1'b0, 1'b1,1'b0,1'b0, 4'd5},  // R5 boot -> 5
        '{1'b0,3'd0,12'h000, 1'b1,3'd0,16'h0500,1'b0, 1'b0,1'b1,1'b0, 4'd5},  // R5
        '{1'b1,3'd1,12'h010, 1'b1,3'd1,16'h0000,1'b0, 1'b0,1'b1,1'b0, 4'd3},  // R3 lim = boot size
        '{1'b1,3'd1,12'h012, 1'b1,3'd1,16'h01FF,1'b0, 1'b1,1'b0,1'b0, 4'd3},  // R3
        '{1'b0,3'd0,12'h000, 1'b1,3'd1,16'h0200,1'b0, 1'b0,1'b1,1'b0, 4'd3},  // R3
        '{1'b1,3'd1,12'h0FF, 1'b1,3'd1,16'h1FFF,1'b0, 1'b1,1'b0,1'b0, 4'd3},  // R3 full
        '{1'b1,3'd2,12'h203, 1'b1,3'd2,16'h02FF,1'b0, 1'b1,1'b0,1'b0, 4'd5},  // R5 ram0 -> 3
        '{1'b0,3'd0,12'h000, 1'b1,3'd2,16'h0300,1'b0, 1'b0,1'b1,1'b0, 4'd2},  // R2
        '{1'b1,3'd4,12'hF03, 1'b1,3'd4,16'h7FFF,1'b0, 1'b1,1'b0,1'b0, 4'd2},  // R2 flash full
        '{1'b0,3'd0,12'h000, 1'b1,3'd4,16'h8000,1'b0, 1'b0,1'b1,1'b1, 4'd10}, // R10 beyond size
        '{1'b1,3'd7,12'h002, 1'b1,3'd4,16'h1FFF,1'b1, 1'b1,1'b0,1'b0, 4'd7},  // R7 flash /4
        '{1'b0,3'd0,12'h000, 1'b1,3'd4,16'h2000,1'b1, 1'b0,1'b1,1'b1, 4'd7},  // R7
        '{1'b1,3'd7,12'h001, 1'b1,3'd4,16'h0FFF,1'b1, 1'b1,1'b0,1'b0, 4'd8},  // R8 -> 3
        '{1'b0,3'd0,12'h000, 1'b1,3'd4,16'h1000,1'b1, 1'b0,1'b1,1'b1, 4'd8},  // R8
        '{1'b1,3'd7,12'h000, 1'b1,3'd4,16'h1000,1'b1, 1'b0,1'b1,1'b1, 4'd8},  // R8 zero write
        '{1'b1,3'd5,12'h001, 1'b1,3'd2,16'h1000,1'b0, 1'b0,1'b1,1'b1, 4'd9},  // R9 both fail
        '{1'b0,3'd0,12'h000, 1'b1,3'd2,16'h0300,1'b0, 1'b0,1'b1,1'b0, 4'd9},  // R9 priv only
        '{1'b0,3'd0,12'h000, 1'b1,3'd2,16'h0FFF,1'b1, 1'b1,1'b0,1'b0, 4'd7},  // R7
        '{1'b0,3'd0,12'h000, 1'b1,3'd5,16'h0000,1'b1, 1'b0,1'b1,1'b0, 4'd10}, // R10 code 5
        '{1'b0,3'd0,12'h000, 1'b1,3'd7,16'h0000,1'b0, 1'b0,1'b1,1'b0, 4'd10}, // R10 code 7
        '{1'b1,3'd3,12'h000, 1'b1,3'd3,16'h0000,1'b0, 1'b0,1'b1,1'b0, 4'd2},  // R2 ram1 lim 0
        '{1'b0,3'd0,12'h000, 1'b1,3'd3,16'h0FFF,1'b1, 1'b1,1'b0,1'b0, 4'd4},  // R4
        '{1'b1,3'd6,12'h007, 1'b1,3'd3,16'h001F,1'b1, 1'b1,1'b0,1'b0, 4'd7},  // R7 ram1 /128
        '{1'b0,3'd0,12'h000, 1'b1,3'd3,16'h0020,1'b1, 1'b0,1'b1,1'b1, 4'd7},  // R7
        '{1'b0,3'd0,12'h000, 1'b0,3'd0,16'h0000,1'b0, 1'b0,1'b0,1'b0, 4'd1},  // R1 idle
        '{1'b1,3'd0,12'h010, 1'b1,3'd0,16'h0FFF,1'b0, 1'b1,1'b0,1'b0, 4'd2}   // R2 lim = size
    };

    task automatic check(input logic eo, ee, ec, input int req);
        checks++;
        if ({acc_ok, acc_err, acc_cap_err} !== {eo, ee, ec}) begin
            fails++;
            $display("FAIL R%0d ok/err/cap actual=%b%b%b expected=%b%b%b",
                     req, acc_ok, acc_err, acc_cap_err, eo, ee, ec);
        end
    endtask

    task automatic access(input logic [2:0] m, input logic [15:0] a, input logic p);
        acc_valid = 1'b1; acc_mem = m; acc_addr = a; acc_priv = p;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cfg_we = VECS[i].wr; cfg_sel = VECS[i].sel; cfg_wdata = VECS[i].wd;
            acc_valid = VECS[i].v; acc_mem = VECS[i].mem;
            acc_addr = VECS[i].addr; acc_priv = VECS[i].pr;
            @(posedge clk); #2;
            cfg_we = 1'b0;
            check(VECS[i].eo, VECS[i].ee, VECS[i].ec, int'(VECS[i].req));
        end

        // R11: a limit write is not seen before its clock edge, and is seen after it
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 12'h000;
        access(3'd0, 16'h0000, 1'b0);
        @(posedge clk); #2; cfg_we = 1'b0;
        check(1'b0, 1'b1, 1'b0, 11);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 12'h001;
        #2 check(1'b0, 1'b1, 1'b0, 11); // R11 before edge
        @(posedge clk); #2; cfg_we = 1'b0;
        check(1'b1, 1'b0, 1'b0, 11);    // R11 after edge

        // R6: a mid-run reset restores limits and clears capacity codes
        @(negedge clk); rst = 1'b1; acc_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        access(3'd0, 16'h0000, 1'b0);
        #2 check(1'b0, 1'b1, 1'b0, 6);
        @(negedge clk); access(3'd3, 16'h0FFF, 1'b0);
        #2 check(1'b1, 1'b0, 1'b0, 6);
        @(negedge clk); access(3'd4, 16'h7FFF, 1'b1);
        #2 check(1'b1, 1'b0, 1'b0, 6);
        @(negedge clk); access(3'd2, 16'h1FFF, 1'b1);
        #2 check(1'b1, 1'b0, 1'b0, 6);
        @(negedge clk); access(3'd1, 16'h0000, 1'b0);
        #2 check(1'b0, 1'b1, 1'b0, 6);

        @(negedge clk); acc_valid = 1'b0;
        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule